// File: doc/BRIEF.md
# Streaming Bitonic Tuple Merger

The block merges two ascending streams into one ascending stream. A datapath word holds one tuple of N unsigned values that are already in order inside the word. Element i sits at bits `[i*EW +: EW]`, where EW = DATA_W/N, and element 0 is the smallest. With the default 256-bit word the block can be built for N=4 (64-bit values) or N=2 (128-bit values).

A merge begins with a `start` pulse. The pulse carries `len_a` and `len_b`, the length of each input sequence counted in tuples. The block first takes the head tuple of both inputs. After that it holds the upper half of every compare in a register. Each cycle it runs that register against the head of one input only. The input is chosen by which side had the larger maximum in the previous compare.

When the input chosen next has no tuples left, the block emits the held tuple. It then passes the rest of the other input straight through. This yields one merged tuple per cycle whatever the values are.

Every data interface uses valid/ready. A transfer happens on a clock edge where both are high. While `m_valid` is high and `m_ready` is low, the output tuple and its last flag hold still. Input readies come from the block's own state and from the output slot, and may drop at any time. A source must keep its tuple presented until it is taken. `start`, the lengths and `busy` are plain level pins.

Top module: `tuple_merger`

## Requirements
- R1: Every output tuple is ascending: element 0 (bits [EW-1:0]) is the smallest and the values are compared as unsigned.
- R2: Within one merge, the first element of each output tuple is not smaller than the last element of the tuple before it.
- R3: The output of a merge is exactly the sorted union of all values of both input sequences, duplicates included.
- R4: A merge emits exactly len_a+len_b tuples. m_last is high on the final one only, and nothing is emitted after it.
- R5: When both inputs are always valid and m_ready is always high, m_valid stays high on every cycle from the first output tuple to the last.
- R6: While m_valid is high and m_ready is low, m_valid stays high and m_data and m_last stay unchanged. Output stalls never lose or duplicate a tuple.
- R7: If one length is zero, the other input passes through unchanged. If both lengths are zero, no tuple is emitted and busy stays low.
- R8: A start pulse while busy is high is ignored, and the running merge completes with its original lengths.
- R9: a_ready and b_ready are low whenever busy is low.
- R10: After reset, m_valid and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a merge when busy is low |
| len_a | input | LEN_W | Tuples in sequence A, sampled with start |
| len_b | input | LEN_W | Tuples in sequence B, sampled with start |
| busy | output | 1 | A merge is running or an output tuple is pending |
| a_valid | input | 1 | Tuple on a_data is offered |
| a_ready | output | 1 | Block takes a_data this cycle |
| a_data | input | DATA_W | Sorted input tuple, stream A |
| b_valid | input | 1 | Tuple on b_data is offered |
| b_ready | output | 1 | Block takes b_data this cycle |
| b_data | input | DATA_W | Sorted input tuple, stream B |
| m_valid | output | 1 | Merged tuple on m_data is valid |
| m_ready | input | 1 | Sink accepts m_data |
| m_data | output | DATA_W | Merged, sorted output tuple |
| m_last | output | 1 | Marks the final tuple of a merge |

## Verification
Five properties are checked on every cycle by the assertions: the order inside each output tuple, the order from one output tuple to the next, the tuple count against the announced lengths together with the placement of the last flag, the output holding still under back-pressure, and input readies staying low while idle. Some behaviour only the bench scenarios can show. That covers the content of the output as the exact sorted union of the inputs, the lack of gaps at full throughput, the zero-length pass-through cases and a start pulse ignored mid-merge. For these the bench sweeps every length pair up to four tuples per side with arithmetic data that includes duplicates and values near the top of the unsigned range.

// File: rtl/merge_pkg.sv
package merge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_RUN,
    ST_FLUSH,
    ST_DRAIN
  } mstate_t;

  localparam logic SRC_A = 1'b0;
  localparam logic SRC_B = 1'b1;
endpackage

// File: rtl/bitonic_sort_net.sv
// Sorts a bitonic sequence of N elements into ascending order (N a power of two).
module bitonic_sort_net #(
  parameter int N  = 4,
  parameter int EW = 64
) (
  input  logic [N*EW-1:0] din,
  output logic [N*EW-1:0] dout
);
  localparam int STG = $clog2(N);

  logic [EW-1:0] lane [0:STG][0:N-1];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign lane[0][i] = din[i*EW +: EW];
    assign dout[i*EW +: EW] = lane[STG][i];
  end

  for (genvar s = 0; s < STG; s++) begin : g_stage
    localparam int D = N >> (s + 1);
    for (genvar i = 0; i < N; i++) begin : g_lane
      if ((i / D) % 2 == 0) begin : g_cmp
        logic swap;
        assign swap = lane[s][i] > lane[s][i+D];
        assign lane[s+1][i]   = swap ? lane[s][i+D] : lane[s][i];
        assign lane[s+1][i+D] = swap ? lane[s][i]   : lane[s][i+D];
      end
    end
  end
endmodule

// File: rtl/merge_core.sv
// Half-cleans the held tuple against the reversed fresh tuple, sorts both halves.
module merge_core #(
  parameter int N  = 4,
  parameter int EW = 64
) (
  input  logic [N*EW-1:0] held,
  input  logic [N*EW-1:0] fresh,
  output logic [N*EW-1:0] lo_sorted,
  output logic [N*EW-1:0] hi_sorted,
  output logic            fresh_wins
);
  logic [N*EW-1:0] lo_raw, hi_raw;

  for (genvar i = 0; i < N; i++) begin : g_hc
    logic [EW-1:0] x, y;
    assign x = held[i*EW +: EW];
    assign y = fresh[(N-1-i)*EW +: EW];
    assign lo_raw[i*EW +: EW] = (x <= y) ? x : y;
    assign hi_raw[i*EW +: EW] = (x <= y) ? y : x;
  end

  bitonic_sort_net #(.N(N), .EW(EW)) u_lo_sort (.din(lo_raw), .dout(lo_sorted));
  bitonic_sort_net #(.N(N), .EW(EW)) u_hi_sort (.din(hi_raw), .dout(hi_sorted));

  // fresh tuple reached at least the held maximum: next pull from the other side
  assign fresh_wins = fresh[(N-1)*EW +: EW] >= held[(N-1)*EW +: EW];
endmodule

// File: rtl/tuple_merger.sv
module tuple_merger #(
  parameter int DATA_W = 256,
  parameter int N      = 4,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_a,
  input  logic [LEN_W-1:0]  len_b,
  output logic              busy,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [DATA_W-1:0] b_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last
);
  import merge_pkg::*;

  localparam int EW = DATA_W / N;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  mstate_t           st_q;
  logic [LEN_W-1:0]  rem_a_q, rem_b_q;
  logic              sel_q;
  logic [DATA_W-1:0] held_q;
  logic              out_v_q, out_last_q;
  logic [DATA_W-1:0] out_d_q;

  logic              adv, fire, take_a, take_b;
  logic              sel_eff, nsel, nsel_empty;
  logic [LEN_W-1:0]  rem_a_n, rem_b_n, rem_src;
  logic [DATA_W-1:0] core_held, core_fresh, src_data, lo_s, hi_s;
  logic              fresh_wins;

  assign adv      = !out_v_q || m_ready;
  assign busy     = (st_q != ST_IDLE) || out_v_q;
  assign sel_eff  = (st_q == ST_FIRST) ? SRC_B : sel_q;
  assign src_data = sel_q ? b_data : a_data;
  assign rem_src  = sel_q ? rem_b_q : rem_a_q;

  assign core_held  = (st_q == ST_FIRST) ? a_data : held_q;
  assign core_fresh = sel_eff ? b_data : a_data;

  merge_core #(.N(N), .EW(EW)) u_core (
    .held      (core_held),
    .fresh     (core_fresh),
    .lo_sorted (lo_s),
    .hi_sorted (hi_s),
    .fresh_wins(fresh_wins)
  );

  always_comb begin
    a_ready = 1'b0;
    b_ready = 1'b0;
    case (st_q)
      ST_FIRST: begin
        a_ready = adv && b_valid;
        b_ready = adv && a_valid;
      end
      ST_RUN, ST_DRAIN: begin
        a_ready = adv && (sel_q == SRC_A);
        b_ready = adv && (sel_q == SRC_B);
      end
      default: ;
    endcase
  end

  assign take_a = a_valid && a_ready;
  assign take_b = b_valid && b_ready;

  always_comb begin
    case (st_q)
      ST_FIRST:         fire = take_a && take_b;
      ST_RUN, ST_DRAIN: fire = take_a || take_b;
      ST_FLUSH:         fire = adv;
      default:          fire = 1'b0;
    endcase
  end

  assign rem_a_n    = rem_a_q - {{(LEN_W-1){1'b0}}, take_a};
  assign rem_b_n    = rem_b_q - {{(LEN_W-1){1'b0}}, take_b};
  assign nsel       = fresh_wins ? !sel_eff : sel_eff;
  assign nsel_empty = nsel ? (rem_b_n == '0) : (rem_a_n == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      rem_a_q    <= '0;
      rem_b_q    <= '0;
      sel_q      <= SRC_A;
      held_q     <= '0;
      out_v_q    <= 1'b0;
      out_last_q <= 1'b0;
      out_d_q    <= '0;
    end else begin
      if (fire) out_v_q <= 1'b1;
      else if (m_ready) out_v_q <= 1'b0;

      case (st_q)
        ST_IDLE: begin
          if (start && !busy) begin
            rem_a_q <= len_a;
            rem_b_q <= len_b;
            if (len_a == '0 && len_b == '0) st_q <= ST_IDLE;
            else if (len_a == '0) begin st_q <= ST_DRAIN; sel_q <= SRC_B; end
            else if (len_b == '0) begin st_q <= ST_DRAIN; sel_q <= SRC_A; end
            else st_q <= ST_FIRST;
          end
        end
        ST_FIRST, ST_RUN: begin
          if (fire) begin
            out_d_q    <= lo_s;
            out_last_q <= 1'b0;
            held_q     <= hi_s;
            sel_q      <= nsel;
            rem_a_q    <= rem_a_n;
            rem_b_q    <= rem_b_n;
            st_q       <= nsel_empty ? ST_FLUSH : ST_RUN;
          end
        end
        ST_FLUSH: begin
          if (fire) begin
            out_d_q    <= held_q;
            out_last_q <= (rem_a_q == '0) && (rem_b_q == '0);
            if (rem_a_q == '0 && rem_b_q == '0) st_q <= ST_IDLE;
            else begin
              st_q  <= ST_DRAIN;
              sel_q <= (rem_a_q != '0) ? SRC_A : SRC_B;
            end
          end
        end
        ST_DRAIN: begin
          if (fire) begin
            out_d_q    <= src_data;
            out_last_q <= (rem_src == ONE);
            rem_a_q    <= rem_a_n;
            rem_b_q    <= rem_b_n;
            if (rem_src == ONE) st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign m_valid = out_v_q;
  assign m_data  = out_d_q;
  assign m_last  = out_last_q;
endmodule

// File: rtl/tuple_merger_checker.sv
module tuple_merger_checker #(
  parameter int DATA_W = 256,
  parameter int N      = 4,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LEN_W-1:0]  len_a,
  input logic [LEN_W-1:0]  len_b,
  input logic              busy,
  input logic              a_ready,
  input logic              b_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_last
);
  localparam int EW = DATA_W / N;

  logic [LEN_W:0]  total_q, cnt_q;
  logic [EW-1:0]   prev_max_q;
  logic            have_prev_q;

  function automatic logic tuple_asc(input logic [DATA_W-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int i = 1; i < N; i++)
      if (d[i*EW +: EW] < d[(i-1)*EW +: EW]) ok = 1'b0;
    return ok;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q     <= '0;
      cnt_q       <= '0;
      prev_max_q  <= '0;
      have_prev_q <= 1'b0;
    end else begin
      if (start && !busy) begin
        total_q <= {1'b0, len_a} + {1'b0, len_b};
        cnt_q   <= '0;
      end
      if (m_valid && m_ready) begin
        cnt_q       <= m_last ? '0 : cnt_q + 1'b1;
        have_prev_q <= !m_last;
        prev_max_q  <= m_data[(N-1)*EW +: EW];
      end
    end
  end

  p_tuple_sorted_r1: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> tuple_asc(m_data));

  p_stream_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && have_prev_q) |-> (m_data[EW-1:0] >= prev_max_q));

  p_count_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |-> (m_last == (cnt_q + 1'b1 == total_q)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  p_idle_noready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!a_ready && !b_ready));
endmodule

bind tuple_merger tuple_merger_checker #(.DATA_W(DATA_W), .N(N), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .len_a(len_a), .len_b(len_b),
  .busy(busy), .a_ready(a_ready), .b_ready(b_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
);

// File: tb/tuple_merger_tb_top.sv
`timescale 1ns/1ps
module tuple_merger_tb_top;
  localparam int DATA_W = 256;
  localparam int N      = 4;
  localparam int LEN_W  = 16;
  localparam int EW     = DATA_W / N;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  len_a = '0, len_b = '0;
  logic              busy;
  logic              a_valid = 1'b0, b_valid = 1'b0, m_ready = 1'b0;
  logic              a_ready, b_ready, m_valid, m_last;
  logic [DATA_W-1:0] a_data = '0, b_data = '0, m_data;

  int errors = 0;
  int checks = 0;
  int wd = 0;
  bit done = 0;

  logic [EW-1:0] ea [0:63];
  logic [EW-1:0] eb [0:63];
  logic [EW-1:0] ex [0:63];

  always #10 clk = ~clk;

  tuple_merger #(.DATA_W(DATA_W), .N(N), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len_a(len_a), .len_b(len_b),
    .busy(busy), .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pack_a(input int t);
    logic [DATA_W-1:0] w;
    for (int e = 0; e < N; e++) w[e*EW +: EW] = ea[(t*N+e) % 64];
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_b(input int t);
    logic [DATA_W-1:0] w;
    for (int e = 0; e < N; e++) w[e*EW +: EW] = eb[(t*N+e) % 64];
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_x(input int t);
    logic [DATA_W-1:0] w;
    for (int e = 0; e < N; e++) w[e*EW +: EW] = ex[(t*N+e) % 64];
    return w;
  endfunction

  function automatic bit is_asc(input logic [DATA_W-1:0] d);
    for (int e = 1; e < N; e++) if (d[e*EW +: EW] < d[(e-1)*EW +: EW]) return 0;
    return 1;
  endfunction

  // arithmetic data: non-decreasing by construction, with duplicates
  task automatic build(input int la, input int lb, input int seed);
    logic [EW-1:0] base;
    int na, nb, k;
    logic [EW-1:0] v;
    base = seed[0] ? 64'hFFFF_FFFF_FFFF_FF00 : 64'd0;
    na = la * N;
    nb = lb * N;
    for (int i = 0; i < na; i++)
      ea[i] = (i == 0) ? base + EW'(seed % 3) : ea[i-1] + EW'((i*5 + seed*3 + (i>>2)) % 4);
    for (int i = 0; i < nb; i++)
      eb[i] = (i == 0) ? base + EW'(seed % 5) : eb[i-1] + EW'((i*7 + seed + 1) % 3);
    for (int i = 0; i < na; i++) ex[i] = ea[i];
    for (int i = 0; i < nb; i++) begin
      v = eb[i];
      k = na + i;
      while (k > 0 && ex[k-1] > v) begin
        ex[k] = ex[k-1];
        k--;
      end
      ex[k] = v;
    end
  endtask

  task automatic run_merge(input int la, input int lb, input int mode, input bit inject);
    int seed, ia, ib, no, cyc, bubbles, total;
    bit pend_a, pend_b, seen, stall_prev;
    logic [DATA_W-1:0] d_prev;
    logic l_prev;
    seed = la*5 + lb + mode*25 + (inject ? 7 : 0);
    build(la, lb, seed);
    total = la + lb;
    ia = 0; ib = 0; no = 0; cyc = 0; bubbles = 0;
    pend_a = 0; pend_b = 0; seen = 0; stall_prev = 0;
    d_prev = '0; l_prev = 1'b0;

    @(negedge clk);
    start = 1'b1; len_a = LEN_W'(la); len_b = LEN_W'(lb);
    a_valid = 1'b1; b_valid = 1'b1; a_data = pack_a(0); b_data = pack_b(0);
    m_ready = 1'b1;
    #9;
    check(!a_ready && !b_ready, "R9 ready while idle",
          DATA_W'({a_ready, b_ready}), '0);

    while (no < total && cyc < 400) begin
      @(negedge clk);
      cyc++;
      start = (inject && cyc == 4);
      len_a = inject ? LEN_W'(1) : LEN_W'(la);
      len_b = inject ? LEN_W'(1) : LEN_W'(lb);
      a_valid = (ia < la) && (pend_a || mode == 0 || ((cyc + seed) % 3 != 0));
      b_valid = (ib < lb) && (pend_b || mode == 0 || ((cyc*2 + seed) % 5 != 1));
      a_data  = pack_a(ia);
      b_data  = pack_b(ib);
      m_ready = (mode == 0) || ((cyc*7 + seed) % 4 != 0);
      #9;
      if (stall_prev)
        check(m_valid && m_data == d_prev && m_last == l_prev, "R6 hold under stall",
              m_data, d_prev);
      pend_a = a_valid && !a_ready;
      pend_b = b_valid && !b_ready;
      if (a_valid && a_ready) ia++;
      if (b_valid && b_ready) ib++;
      if (m_valid) seen = 1;
      else if (seen) bubbles++;
      stall_prev = m_valid && !m_ready;
      d_prev = m_data;
      l_prev = m_last;
      if (m_valid && m_ready) begin
        check(is_asc(m_data), "R1 tuple ascending", m_data, pack_x(no));
        check(m_data == pack_x(no), (la == 0 || lb == 0) ? "R7 pass-through" : "R3 merged content",
              m_data, pack_x(no));
        check(m_last == (no == total - 1), "R4 last flag", DATA_W'(m_last),
              DATA_W'(no == total - 1));
        no++;
      end
    end
    check(no == total, inject ? "R8 start ignored while busy" : "R4 tuple count",
          DATA_W'(no), DATA_W'(total));
    check(ia == la && ib == lb, "R3 all inputs consumed",
          DATA_W'({ia[15:0], ib[15:0]}), DATA_W'({la[15:0], lb[15:0]}));
    if (mode == 0 && total > 0)
      check(bubbles == 0, "R5 full throughput", DATA_W'(bubbles), '0);

    @(negedge clk);
    start = 1'b0; a_valid = 1'b0; b_valid = 1'b0; m_ready = 1'b1;
    #9;
    check(!m_valid && !busy, (total == 0) ? "R7 both empty stays idle" : "R4 nothing after last",
          DATA_W'({m_valid, busy}), '0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #9;
    check(!m_valid && !busy, "R10 reset state", DATA_W'({m_valid, busy}), '0);
    @(negedge clk);
    rst_n = 1'b1;
    #9;
    check(!m_valid && !busy, "R10 out of reset", DATA_W'({m_valid, busy}), '0);

    for (int mode = 0; mode < 2; mode++)
      for (int la = 0; la <= 4; la++)
        for (int lb = 0; lb <= 4; lb++)
          run_merge(la, lb, mode, 1'b0);

    run_merge(3, 2, 1, 1'b1);  // R8
    run_merge(4, 4, 1, 1'b1);  // R8

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule